// File: doc/BRIEF.md
# FM Operator Phase Generator

This block produces the running phase of one FM synthesis operator. Each accepted sample strobe starts a short, fixed sequence. The first step forms a base increment from an 11-bit frequency number and a 3-bit octave block. The next step adds or subtracts a detune offset in 17-bit unsigned arithmetic. The step after that scales the result by a frequency multiple. The last step adds the scaled increment to a 20-bit phase accumulator.

The top ten accumulator bits are presented as the phase that addresses a downstream sine table. The detune sum is never clamped. A negative offset larger than the base increment wraps to a value near the top of the 17-bit range. A zero frequency number with negative detune therefore gives a high continuous tone rather than silence.

A small sequencer orders the work. S_IDLE waits for a strobe and moves to S_SUM when one arrives. S_SUM registers the detuned sum and moves to S_SCALE. S_SCALE registers the scaled increment and moves to S_ACCUM. S_ACCUM updates the accumulator and returns to S_IDLE. A key-on pulse, or a reset, sends any state straight back to S_IDLE and zeroes the accumulator.

Top module: `fm_phase_gen`

## Requirements
- R1: Synchronous reset (rst high at a rising edge) clears the accumulator, so phase reads 0, and puts the sequencer in S_IDLE.
- R2: The key code is 5 bits, {block, fnum[10], n}. The bit n equals OR(fnum[9:7]) when fnum[10] is 1, and AND(fnum[9:7]) when fnum[10] is 0.
- R3: Detune is a 3-bit field. Magnitude m = detune[1:0] and offset = m × (keycode + 1). Codes 0 and 4 add nothing, 1..3 add the offset, and 5..7 subtract it.
- R4: The base increment is (fnum << block) >> 1, which is 17 bits. Block 7 with fnum 0x7FF gives 0x1FFC0.
- R5: The detuned sum is taken modulo 2^17. For example, fnum 0 with detune 7 gives 0x1FFFD, and with detune 5 gives 0x1FFFF.
- R6: A multiple of 0 halves the sum (shift right by 1). A multiple of 1..15 multiplies the sum. The product is truncated to its low 20 bits.
- R7: Each accepted strobe adds the increment to the 20-bit accumulator modulo 2^20. The phase output is accumulator bits [19:10].
- R8: A strobe sampled at rising edge E0 changes phase at edge E0+3 and not before it. Inputs are sampled at edge E0+1.
- R9: A strobe that arrives while the sequencer is outside S_IDLE is ignored and starts no second update.
- R10: key_on high at an edge zeroes the accumulator, cancels any update in progress and returns to S_IDLE. It takes priority over a strobe at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sample strobe, one cycle wide |
| key_on | input | 1 | Key-on pulse, resets phase |
| fnum | input | 11 | Frequency number |
| block | input | 3 | Octave block |
| detune | input | 3 | Sign-magnitude detune code |
| multiple | input | 4 | Frequency multiple (0 means one half) |
| phase | output | 10 | Upper accumulator bits for sine addressing |

## Verification
An update lands three rising edges after the edge that accepts the strobe. Two of those edges are register stages for the sum and the increment; the third writes the accumulator. The bench drives the strobe on a falling edge and waits four falling edges before it reads the phase. In the timing test it also reads the phase after two falling edges to confirm the old value is still present. A key-on pulse acts at the very next edge, so the checks that follow a key-on are made one falling edge later. Each vector runs a known number of strobes from a cleared accumulator, so the expected phase is the wrapped product of that count and the increment computed by hand.

// File: rtl/fm_pg_pkg.sv
package fm_pg_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SUM,
        S_SCALE,
        S_ACCUM
    } pg_state_e;

endpackage

// File: rtl/fm_pg_detune.sv
module fm_pg_detune #(
    parameter int FNUM_W = 11,
    parameter int BLK_W  = 3,
    parameter int DT_W   = 3,
    parameter int SUM_W  = 17
) (
    input  logic [FNUM_W-1:0] fnum,
    input  logic [BLK_W-1:0]  block,
    input  logic [DT_W-1:0]   detune,
    output logic [SUM_W-1:0]  sum
);
    localparam int WIDE_W = FNUM_W + (1 << BLK_W) - 1;
    localparam int KC_W   = BLK_W + 2;

    logic [WIDE_W-1:0] shifted;
    logic [SUM_W-1:0]  base;
    logic [SUM_W-1:0]  offset;
    logic [KC_W-1:0]   keycode;
    logic              n_bit;

    always_comb begin
        // R2 key code from block and top frequency bits
        if (fnum[FNUM_W-1])
            n_bit = |fnum[FNUM_W-2 -: 3];
        else
            n_bit = &fnum[FNUM_W-2 -: 3];
        keycode = {block, fnum[FNUM_W-1], n_bit};
    end

    always_comb begin
        // R4 base increment
        shifted = WIDE_W'(fnum) << block;
        base    = SUM_W'(shifted >> 1);
        // R3 offset magnitude
        offset  = SUM_W'(detune[DT_W-2:0]) * (SUM_W'(keycode) + SUM_W'(1));
        // R5 unsigned, modulo 2^SUM_W
        if (detune[DT_W-1])
            sum = base - offset;
        else
            sum = base + offset;
    end

    always_comb begin
        // R5
        if (detune[DT_W-1] && offset > base) begin
            wrap_chk: assert (sum > base);
        end
    end

endmodule

// File: rtl/fm_pg_scale.sv
module fm_pg_scale #(
    parameter int SUM_W = 17,
    parameter int MUL_W = 4,
    parameter int ACC_W = 20
) (
    input  logic [SUM_W-1:0] sum,
    input  logic [MUL_W-1:0] multiple,
    output logic [ACC_W-1:0] inc
);
    localparam int PROD_W = SUM_W + MUL_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        // R6 zero multiple means one half
        if (multiple == '0)
            prod = PROD_W'(sum >> 1);
        else
            prod = PROD_W'(sum) * PROD_W'(multiple);
    end

    generate
        if (ACC_W >= PROD_W) begin : g_pad
            assign inc = ACC_W'(prod);
        end else begin : g_trunc
            assign inc = prod[ACC_W-1:0];
        end
    endgenerate

    always_comb begin
        // R6
        if (multiple == '0) begin
            half_chk: assert (PROD_W'(inc) <= PROD_W'(sum));
        end
    end

endmodule

// File: rtl/fm_phase_gen.sv
module fm_phase_gen
    import fm_pg_pkg::*;
#(
    parameter int FNUM_W = 11,
    parameter int BLK_W  = 3,
    parameter int DT_W   = 3,
    parameter int MUL_W  = 4,
    parameter int SUM_W  = 17,
    parameter int ACC_W  = 20,
    parameter int PH_W   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              key_on,
    input  logic [FNUM_W-1:0] fnum,
    input  logic [BLK_W-1:0]  block,
    input  logic [DT_W-1:0]   detune,
    input  logic [MUL_W-1:0]  multiple,
    output logic [PH_W-1:0]   phase
);
    pg_state_e        state_q, state_d;
    logic [SUM_W-1:0] sum_w, sum_q;
    logic [ACC_W-1:0] inc_w, inc_q;
    logic [ACC_W-1:0] acc_q;

    fm_pg_detune #(
        .FNUM_W(FNUM_W), .BLK_W(BLK_W), .DT_W(DT_W), .SUM_W(SUM_W)
    ) u_detune (
        .fnum(fnum), .block(block), .detune(detune), .sum(sum_w)
    );

    fm_pg_scale #(
        .SUM_W(SUM_W), .MUL_W(MUL_W), .ACC_W(ACC_W)
    ) u_scale (
        .sum(sum_q), .multiple(multiple), .inc(inc_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (tick) state_d = S_SUM;
            S_SUM:   state_d = S_SCALE;
            S_SCALE: state_d = S_ACCUM;
            S_ACCUM: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || key_on)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            inc_q <= '0;
            acc_q <= '0;
        end else if (key_on) begin
            acc_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE:  ;
                S_SUM:   sum_q <= sum_w;
                S_SCALE: inc_q <= inc_w;
                S_ACCUM: acc_q <= acc_q + inc_q;
            endcase
        end
    end

    assign phase = acc_q[ACC_W-1 -: PH_W];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && state_q == S_IDLE));

    // R10
    key_clear_chk: assert property (@(posedge clk) disable iff (rst)
        key_on |=> (acc_q == '0 && state_q == S_IDLE));

    // R8
    tick_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && tick && !key_on) |=> state_q == S_SUM);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE && !key_on) |=> state_q != S_SUM);

    // R7
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_ACCUM && !key_on) |=> $stable(acc_q));

endmodule

// File: tb/fm_phase_gen_test.sv
module fm_phase_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        key_on = 1'b0;
    logic [10:0] fnum = '0;
    logic [2:0]  block = '0;
    logic [2:0]  detune = '0;
    logic [3:0]  multiple = 4'd1;
    logic [9:0]  phase;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    fm_phase_gen uut (
        .clk(clk), .rst(rst), .tick(tick), .key_on(key_on),
        .fnum(fnum), .block(block), .detune(detune),
        .multiple(multiple), .phase(phase)
    );

    localparam int NV = 14;
    localparam int V_FNUM [NV] = '{'h000,'h000,'h000,'h000,'h000,'h7FF,'h400,
                                   'h400,'h400,'h400,'h7FF,'h380,'h480,'h000};
    localparam int V_BLK  [NV] = '{0,0,0,0,0,7,4,4,4,4,7,2,4,0};
    localparam int V_DT   [NV] = '{0,4,7,7,5,0,1,5,0,0,0,3,3,5};
    localparam int V_MUL  [NV] = '{1,1,1,1,1,1,1,1,0,3,15,1,1,1};
    localparam int V_N    [NV] = '{3,3,1,2,8,1,103,103,4,4,1,9,35,9};
    localparam int V_EXP  [NV] = '{'h000,'h000,'h07F,'h0FF,'h3FF,'h07F,'h339,
                                   'h336,'h010,'h060,'h37F,'h010,'h13D,'h07F};

    function automatic string req_of(input int i);
        case (i)
            0, 1, 6, 7: return "R3";
            2, 4:       return "R5";
            5:          return "R4";
            8, 9, 10:   return "R6";
            11, 12:     return "R2";
            default:    return "R7";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_key();
        @(negedge clk) key_on = 1'b1;
        @(negedge clk) key_on = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8: actual hung expected finished run");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", phase, 0);

        for (int i = 0; i < NV; i++) begin
            fnum = 11'(V_FNUM[i]);
            block = 3'(V_BLK[i]);
            detune = 3'(V_DT[i]);
            multiple = 4'(V_MUL[i]);
            pulse_key();
            for (int k = 0; k < V_N[i]; k++) do_tick();
            check(req_of(i), phase, V_EXP[i]);
        end

        // R8 timing: wrapped increment 0x1FFFD, one tick gives 0x07F
        fnum = '0; block = '0; detune = 3'd7; multiple = 4'd1;
        pulse_key();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8", phase, 0);
        @(negedge clk);
        check("R8", phase, 'h07F);

        // R9 second strobe in S_SUM is ignored
        pulse_key();
        @(negedge clk) tick = 1'b1;
        @(negedge clk);
        @(negedge clk) tick = 1'b0;
        repeat (8) @(negedge clk);
        check("R9", phase, 'h07F);

        // R10 key-on cancels an update in flight
        pulse_key();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        @(negedge clk) key_on = 1'b1;
        @(negedge clk) key_on = 1'b0;
        repeat (6) @(negedge clk);
        check("R10", phase, 0);
        do_tick();
        check("R10", phase, 'h07F);

        // R10 key-on beats a simultaneous strobe
        @(negedge clk) begin key_on = 1'b1; tick = 1'b1; end
        @(negedge clk) begin key_on = 1'b0; tick = 1'b0; end
        check("R10", phase, 0);
        repeat (6) @(negedge clk);
        check("R10", phase, 0);

        // R1 reset after activity
        do_tick();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R1", phase, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule